// File: doc/BRIEF.md
# Memory Protection Entry Register File

This block stores the programmable state of a physical memory protection unit: a parameterized number of entries, each with an 8-bit configuration byte and an XLEN-wide address register, plus one security-control register. It sits behind a CSR-style request port. A single request selects one of three register classes and an index, and is either a read or a write. The write rules that keep locked protection state intact are applied inside the block, so software can never bypass them.

The configuration bytes are packed several to a register, one byte per entry. A configuration byte holds read permission in bit 0, write permission in bit 1, execute permission in bit 2, the match mode in bits 4:3 (0 off, 1 top-of-range, 2 naturally aligned four-byte, 3 naturally aligned power-of-two) and the lock flag in bit 7. The security register holds three bits: lockdown in bit 0, whitelist policy in bit 1 and lock-bypass in bit 2. All other bits read as zero.

The block drives the current configuration bytes and addresses of all entries to the address-matching logic downstream. It also drives the number of entries whose match mode is not off, and a one-cycle flush pulse that tells translation caches that protection state has changed.

Top module: `pmp_regfile`

## Requirements
- R1: After reset, every configuration byte, address register and security bit is zero. The active count and the flush pulse are zero.
- R2: Select 0 addresses packed configuration register r. Byte b of that register (bits 8b+7:8b, b below XLEN/8) is the configuration of entry r*4+b. Bytes that map to entries at or above NUM_ENTRIES read as zero, and writes to them are dropped. A write takes effect at the next clock edge and appears on the per-entry outputs.
- R3: A write to the configuration byte of an entry whose lock bit (bit 7) is set is ignored while the bypass bit is clear. When the bypass bit is set, the write is accepted.
- R4: While lockdown is set and bypass is clear, a configuration byte is rejected if its code {bit7, bit0, bit1, bit2} is 9, 10, 11 or 13. Every other code is accepted.
- R5: A write to address register i (select 1) is ignored if entry i is locked and bypass is clear.
- R6: A write to address register i is also ignored if entry i+1 exists, is locked and uses match mode 1 (top-of-range), and bypass is clear. Entry i+1 in any other match mode does not block the write.
- R7: A write to the security register (select 2) cannot change bypass from 0 to 1 while any entry is locked. Bypass can always be cleared.
- R8: Lockdown and whitelist, once set, stay set until reset. Writing zeros does not clear them.
- R9: The active count equals the number of entries whose match mode field is not 0. It is valid in the same cycle as the configuration it describes.
- R10: The flush output is high for exactly the one cycle after an edge where an accepted write changed a configuration byte or an address register, or newly set lockdown or whitelist. It stays low for writes that change nothing or are rejected.
- R11: A read request returns valid data one cycle later. Address reads at or above NUM_ENTRIES return zero, and reads of the security register return the three bits at their positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_sel | input | 2 | 0 packed configuration, 1 address, 2 security |
| req_idx | input | IDX_W | Register index within the selected class |
| req_wdata | input | XLEN | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | XLEN | Read data |
| cfg_out | output | NUM_ENTRIES*8 | Configuration byte of entry i at bits 8i+7:8i |
| addr_out | output | NUM_ENTRIES*XLEN | Address register of entry i |
| active_cnt | output | CNT_W | Entries with a match mode other than off |
| flush | output | 1 | One-cycle protection-change pulse |

## Verification
The assertions check several properties on every cycle: the sticky security bits never fall, a locked configuration byte never changes while bypass is clear, and bypass never rises while a lock is present. They also check that a flush follows a write, that every configuration change comes with a flush, and that read responses follow read requests. The bench scenarios are needed for the remaining behaviours. These are the full legality table under lockdown, the packing of bytes onto entries, the top-of-range neighbour lock on address writes, the exact count values, and the absence of a flush after a write that changes nothing.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_SEC  = 2'd2
  } csr_sel_e;

  typedef enum logic [1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_TOR   = 2'd1,
    MATCH_NA4   = 2'd2,
    MATCH_NAPOT = 2'd3
  } match_e;

  // security bits: bypass at 2, whitelist at 1, lockdown at 0
  typedef struct packed {
    logic bypass;
    logic whitelist;
    logic lockdown;
  } sec_t;

  function automatic logic cfg_is_locked(input logic [7:0] c);
    return c[7];
  endfunction

  function automatic match_e cfg_match(input logic [7:0] c);
    return match_e'(c[4:3]);
  endfunction

  // codes {L,R,W,X} not permitted under lockdown
  function automatic logic lockdown_illegal(input logic [7:0] c);
    logic [3:0] code;
    code = {c[7], c[0], c[1], c[2]};
    return (code == 4'd9) || (code == 4'd10) || (code == 4'd11) || (code == 4'd13);
  endfunction

endpackage

// File: rtl/pmp_entry_gate.sv
module pmp_entry_gate
  import pmp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 4,
  parameter int ENTRY = 0
) (
  input  logic             cfg_wr,
  input  logic             addr_wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  wdata,
  input  logic [7:0]       cur_cfg,
  input  logic [XLEN-1:0]  cur_addr,
  input  logic [7:0]       next_cfg,
  input  logic             bypass,
  input  logic             lockdown,
  output logic             cfg_we,
  output logic [7:0]       cfg_wval,
  output logic             addr_we
);
  localparam int BPR = XLEN / 8;

  int              base;
  int              slot;
  logic            hit;
  logic [XLEN-1:0] shifted;
  logic            own_lock;
  logic            next_tor_lock;
  logic            legal;

  always_comb begin
    base    = int'(idx) * 4;
    slot    = ENTRY - base;
    hit     = cfg_wr && (slot >= 0) && (slot < BPR);
    shifted = hit ? (wdata >> (8 * slot)) : '0;
    cfg_wval = shifted[7:0];
  end

  always_comb begin
    own_lock      = cfg_is_locked(cur_cfg) && !bypass;
    next_tor_lock = cfg_is_locked(next_cfg) && (cfg_match(next_cfg) == MATCH_TOR) && !bypass;
    legal         = !(lockdown && !bypass && lockdown_illegal(cfg_wval));
    cfg_we        = hit && !own_lock && legal && (cfg_wval != cur_cfg);
    addr_we       = addr_wr && (int'(idx) == ENTRY) && !own_lock && !next_tor_lock &&
                    (wdata != cur_addr);
  end

endmodule

// File: rtl/pmp_sec_reg.sv
module pmp_sec_reg
  import pmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [2:0] wbits,
  input  logic       any_locked,
  output sec_t       sec_q,
  output logic       sticky_chg
);
  sec_t sec_d;

  always_comb begin
    sec_d = sec_q;
    if (wr) begin
      sec_d.lockdown  = sec_q.lockdown | wbits[0];
      sec_d.whitelist = sec_q.whitelist | wbits[1];
      sec_d.bypass    = wbits[2] & (sec_q.bypass | ~any_locked);
    end
    sticky_chg = (sec_d.lockdown != sec_q.lockdown) || (sec_d.whitelist != sec_q.whitelist);
  end

  always_ff @(posedge clk) begin
    if (rst) sec_q <= '0;
    else     sec_q <= sec_d;
  end

endmodule

// File: rtl/pmp_active_count.sv
module pmp_active_count #(
  parameter int NUM_ENTRIES = 8,
  parameter int CNT_W       = 4
) (
  input  logic [NUM_ENTRIES*8-1:0] cfg_flat,
  output logic [CNT_W-1:0]         count
);
  always_comb begin
    count = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      count = count + CNT_W'(cfg_flat[8*e+3 +: 2] != 2'b00);
    end
  end
endmodule

// File: rtl/pmp_regfile.sv
module pmp_regfile
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int XLEN        = 32,
  parameter int IDX_W       = 4,
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [1:0]                  req_sel,
  input  logic [IDX_W-1:0]            req_idx,
  input  logic [XLEN-1:0]             req_wdata,
  output logic                        rsp_valid,
  output logic [XLEN-1:0]             rsp_rdata,
  output logic [NUM_ENTRIES*8-1:0]    cfg_out,
  output logic [NUM_ENTRIES*XLEN-1:0] addr_out,
  output logic [CNT_W-1:0]            active_cnt,
  output logic                        flush
);
  localparam int BPR = XLEN / 8;

  logic [7:0]      cfg_q  [NUM_ENTRIES];
  logic [XLEN-1:0] addr_q [NUM_ENTRIES];
  logic [7:0]      cfg_wval [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] cfg_we;
  logic [NUM_ENTRIES-1:0] addr_we;
  logic [NUM_ENTRIES-1:0] lock_vec;
  logic [NUM_ENTRIES*8-1:0] cfg_d_flat;
  logic [CNT_W-1:0] cnt_d;
  csr_sel_e sel;
  logic cfg_wr, addr_wr, sec_wr;
  sec_t sec_q;
  logic sticky_chg;
  logic [XLEN-1:0] rd_mux;

  assign sel     = csr_sel_e'(req_sel);
  assign cfg_wr  = req_valid && req_write && (sel == SEL_CFG);
  assign addr_wr = req_valid && req_write && (sel == SEL_ADDR);
  assign sec_wr  = req_valid && req_write && (sel == SEL_SEC);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    logic [7:0] next_cfg;
    if (i + 1 < NUM_ENTRIES) begin : g_nxt
      assign next_cfg = cfg_q[i+1];
    end else begin : g_last
      assign next_cfg = 8'h00;
    end

    pmp_entry_gate #(.XLEN(XLEN), .IDX_W(IDX_W), .ENTRY(i)) u_gate (
      .cfg_wr   (cfg_wr),
      .addr_wr  (addr_wr),
      .idx      (req_idx),
      .wdata    (req_wdata),
      .cur_cfg  (cfg_q[i]),
      .cur_addr (addr_q[i]),
      .next_cfg (next_cfg),
      .bypass   (sec_q.bypass),
      .lockdown (sec_q.lockdown),
      .cfg_we   (cfg_we[i]),
      .cfg_wval (cfg_wval[i]),
      .addr_we  (addr_we[i])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[i]  <= '0;
        addr_q[i] <= '0;
      end else begin
        if (cfg_we[i])  cfg_q[i]  <= cfg_wval[i];
        if (addr_we[i]) addr_q[i] <= req_wdata;
      end
    end

    assign lock_vec[i]            = cfg_is_locked(cfg_q[i]);
    assign cfg_d_flat[8*i +: 8]   = cfg_we[i] ? cfg_wval[i] : cfg_q[i];
    assign cfg_out[8*i +: 8]      = cfg_q[i];
    assign addr_out[XLEN*i +: XLEN] = addr_q[i];
  end

  pmp_sec_reg u_sec (
    .clk        (clk),
    .rst        (rst),
    .wr         (sec_wr),
    .wbits      (req_wdata[2:0]),
    .any_locked (|lock_vec),
    .sec_q      (sec_q),
    .sticky_chg (sticky_chg)
  );

  pmp_active_count #(.NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W)) u_cnt (
    .cfg_flat (cfg_d_flat),
    .count    (cnt_d)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CFG: begin
        for (int b = 0; b < BPR; b++) begin
          for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (e == int'(req_idx) * 4 + b) rd_mux[8*b +: 8] = cfg_q[e];
          end
        end
      end
      SEL_ADDR: begin
        for (int e = 0; e < NUM_ENTRIES; e++) begin
          if (e == int'(req_idx)) rd_mux = addr_q[e];
        end
      end
      SEL_SEC: rd_mux[2:0] = sec_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      active_cnt <= '0;
      flush      <= 1'b0;
    end else begin
      rsp_valid  <= req_valid && !req_write;
      rsp_rdata  <= (req_valid && !req_write) ? rd_mux : '0;
      active_cnt <= cnt_d;
      flush      <= (|cfg_we) || (|addr_we) || sticky_chg;
    end
  end

endmodule

// File: rtl/pmp_regfile_chk.sv
module pmp_regfile_chk #(
  parameter int NUM_ENTRIES = 8,
  parameter int CNT_W       = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_valid,
  input logic                     req_write,
  input logic                     rsp_valid,
  input logic [NUM_ENTRIES*8-1:0] cfg_out,
  input logic [CNT_W-1:0]         active_cnt,
  input logic                     flush,
  input logic [2:0]               sec_bits
);
  logic any_locked;
  always_comb begin
    any_locked = 1'b0;
    for (int e = 0; e < NUM_ENTRIES; e++) any_locked = any_locked | cfg_out[8*e+7];
  end

  // R8
  lockdown_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sec_bits[0]) |-> sec_bits[0]);

  // R8
  whitelist_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sec_bits[1]) |-> sec_bits[1]);

  // R7
  bypass_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sec_bits[2]) |-> !$past(any_locked));

  // R10
  flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> $past(req_valid && req_write));

  // R10
  cfg_change_flush_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_out) |-> flush);

  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write));

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(active_cnt) <= NUM_ENTRIES);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_lock
    // R3
    locked_cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(cfg_out[8*i+7]) && !$past(sec_bits[2])) |-> $stable(cfg_out[8*i +: 8]));
  end

endmodule

bind pmp_regfile pmp_regfile_chk #(.NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .cfg_out    (cfg_out),
  .active_cnt (active_cnt),
  .flush      (flush),
  .sec_bits   (sec_q)
);

// File: tb/tb_pmp_regfile.sv
module tb_pmp_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 6;
  localparam int XL    = 32;
  localparam int IW    = 4;
  localparam int CW    = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [1:0] req_sel = '0;
  logic [IW-1:0] req_idx = '0;
  logic [XL-1:0] req_wdata = '0;
  logic rsp_valid;
  logic [XL-1:0] rsp_rdata;
  logic [N*8-1:0] cfg_out;
  logic [N*XL-1:0] addr_out;
  logic [CW-1:0] active_cnt;
  logic flush;

  int checks = 0;
  int errors = 0;

  logic [7:0]  m_cfg  [N];
  logic [31:0] m_addr [N];
  logic m_ld, m_wl, m_by;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmp_regfile #(.NUM_ENTRIES(N), .XLEN(XL), .IDX_W(IW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .req_idx(req_idx), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cfg_out(cfg_out),
    .addr_out(addr_out), .active_cnt(active_cnt), .flush(flush)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int m_count();
    int c = 0;
    for (int e = 0; e < N; e++) if (m_cfg[e][4:3] != 2'b00) c++;
    return c;
  endfunction

  function automatic logic m_any_lock();
    logic a = 1'b0;
    for (int e = 0; e < N; e++) a = a | m_cfg[e][7];
    return a;
  endfunction

  function automatic logic bad_code(input logic [7:0] v);
    logic [3:0] c;
    c = {v[7], v[0], v[1], v[2]};
    return (c == 9) || (c == 10) || (c == 11) || (c == 13);
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] sel, input int idx);
    logic [31:0] r = '0;
    if (sel == 2'd0) begin
      for (int b = 0; b < 4; b++) if (idx*4 + b < N) r[8*b +: 8] = m_cfg[idx*4 + b];
    end else if (sel == 2'd1) begin
      if (idx < N) r = m_addr[idx];
    end else if (sel == 2'd2) begin
      r = {29'd0, m_by, m_wl, m_ld};
    end
    return r;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int e = 0; e < N; e++) begin m_cfg[e] = '0; m_addr[e] = '0; end
    m_ld = 0; m_wl = 0; m_by = 0;
  endtask

  task automatic check_outputs(input string tag);
    logic [N*8-1:0] ec;
    logic [N*XL-1:0] ea;
    for (int e = 0; e < N; e++) begin ec[8*e +: 8] = m_cfg[e]; ea[XL*e +: XL] = m_addr[e]; end
    check({tag, " R2 cfg_out"}, 64'(cfg_out), 64'(ec));
    for (int e = 0; e < N; e++) check({tag, " R5 addr_out"}, 64'(addr_out[XL*e +: XL]), 64'(ea[XL*e +: XL]));
    check({tag, " R9 active_cnt"}, 64'(active_cnt), 64'(m_count()));
  endtask

  task automatic wr(input logic [1:0] sel, input int idx, input logic [31:0] d, input string tag);
    logic ch = 1'b0;
    if (sel == 2'd0) begin
      for (int b = 0; b < 4; b++) begin
        int e = idx*4 + b;
        logic [7:0] v = d[8*b +: 8];
        if (e < N) begin
          if (!(m_cfg[e][7] && !m_by) && !(m_ld && !m_by && bad_code(v))) begin
            if (v != m_cfg[e]) ch = 1'b1;
            m_cfg[e] = v;
          end
        end
      end
    end else if (sel == 2'd1) begin
      if (idx < N) begin
        logic blk = !m_by && m_cfg[idx][7];
        if (idx + 1 < N && !m_by && m_cfg[idx+1][7] && m_cfg[idx+1][4:3] == 2'd1) blk = 1'b1;
        if (!blk) begin
          if (d != m_addr[idx]) ch = 1'b1;
          m_addr[idx] = d;
        end
      end
    end else if (sel == 2'd2) begin
      logic nby = d[2] && (m_by || !m_any_lock());
      if ((m_ld | d[0]) != m_ld || (m_wl | d[1]) != m_wl) ch = 1'b1;
      m_ld = m_ld | d[0];
      m_wl = m_wl | d[1];
      m_by = nby;
    end
    req_valid = 1'b1; req_write = 1'b1; req_sel = sel;
    req_idx = IW'(idx); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check({tag, " R10 flush"}, 64'(flush), 64'(ch));
    check_outputs(tag);
  endtask

  task automatic rd(input logic [1:0] sel, input int idx, input string tag);
    req_valid = 1'b1; req_write = 1'b0; req_sel = sel; req_idx = IW'(idx);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R11 rsp_valid"}, 64'(rsp_valid), 64'd1);
    check({tag, " rdata"}, 64'(rsp_rdata), 64'(m_read(sel, idx)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    check("R1 flush", 64'(flush), 64'd0);
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check_outputs("R1");
    for (int r = 0; r < 2; r++) rd(2'd0, r, "R1 cfg read");
    for (int a = 0; a < 8; a++) rd(2'd1, a, "R1 addr read");
    rd(2'd2, 0, "R1 sec read");

    // R2 / R9: packing, dropped bytes, count
    wr(2'd0, 0, 32'h1810_0803, "R2 reg0");
    rd(2'd0, 0, "R2 reg0");
    wr(2'd0, 1, 32'hFFFF_0819, "R2 reg1 high bytes dropped");
    rd(2'd0, 1, "R2 reg1");
    rd(2'd0, 2, "R2 reg2 beyond");
    wr(2'd0, 1, 32'hFFFF_0819, "R10 unchanged write");
    // R11: addresses and out-of-range
    for (int a = 0; a < 8; a++) wr(2'd1, a, 32'h1000_0000 + 32'(a) * 32'h111, "R11 addr write");
    for (int a = 0; a < 8; a++) rd(2'd1, a, "R11 addr read");
    wr(2'd0, 0, 32'h0, "R9 clear reg0");

    // R3, R5, R6, R7 with bypass
    do_reset();
    wr(2'd2, 0, 32'h4, "R7 bypass set unlocked");
    rd(2'd2, 0, "R7 sec");
    wr(2'd0, 0, 32'h0098_8901, "R3 lock entries");
    wr(2'd0, 1, 32'h0000_1890, "R3 lock entry4");
    wr(2'd0, 0, 32'h0098_8B01, "R3 bypass rewrite");
    wr(2'd1, 0, 32'hA0, "R6 bypass override");
    wr(2'd1, 1, 32'hA1, "R5 bypass override");
    wr(2'd2, 0, 32'h0, "R7 bypass clear");
    wr(2'd2, 0, 32'h4, "R7 bypass blocked");
    rd(2'd2, 0, "R7 sec");
    wr(2'd0, 0, 32'h0300_0002, "R3 locked ignored");
    rd(2'd0, 0, "R3 readback");
    wr(2'd1, 0, 32'hB0, "R6 next TOR lock");
    wr(2'd1, 1, 32'hB1, "R5 own lock");
    wr(2'd1, 2, 32'hB2, "R5 own lock e2");
    wr(2'd1, 3, 32'hB3, "R6 next NA4 allowed");
    wr(2'd1, 5, 32'hB5, "R6 last entry");
    for (int a = 0; a < N; a++) rd(2'd1, a, "R5 R6 readback");

    // R8: sticky bits
    do_reset();
    wr(2'd2, 0, 32'h3, "R8 set sticky");
    wr(2'd2, 0, 32'h0, "R8 clear attempt");
    rd(2'd2, 0, "R8 sec");

    // R4: legality table under lockdown
    for (int code = 0; code < 16; code++) begin
      logic [7:0] v;
      logic [3:0] c4 = 4'(code);
      v = {c4[3], 4'b0000, c4[0], c4[1], c4[2]};
      do_reset();
      wr(2'd2, 0, 32'h1, "R4 lockdown");
      wr(2'd0, 0, {24'd0, v}, "R4 code write");
      rd(2'd0, 0, "R4 code read");
      check("R4 table", 64'(m_cfg[0]), 64'((code == 9 || code == 10 || code == 11 || code == 13) ? 8'h00 : v));
    end

    // Sweep with model
    for (int blk = 0; blk < 4; blk++) begin
      do_reset();
      for (int op = 0; op < 60; op++) begin
        logic [1:0] sel;
        logic [31:0] d;
        lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
        sel = (lfsr[1:0] == 2'd3) ? 2'd1 : lfsr[1:0];
        d = {lfsr[31:8], lfsr[15:8]};
        if (sel == 2'd0 && lfsr[20:18] != 3'd0) d = d & 32'h7F7F_7F7F;
        if (sel == 2'd2) d = {29'd0, lfsr[9] & lfsr[10], lfsr[11] & lfsr[12], lfsr[13]};
        wr(sel, (sel == 2'd0) ? int'(lfsr[6:5]) % 3 : int'(lfsr[7:5]), d, "R3 R4 R5 R6 R9 sweep");
        if (lfsr[3]) rd(sel, (sel == 2'd0) ? int'(lfsr[6:5]) % 3 : int'(lfsr[7:5]), "R2 sweep read");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule